// File: doc/BRIEF.md
# Nested Prioritized Interrupt Controller

This block collects a parameterized set of level-sensitive interrupt request lines. For each line it keeps an enable bit, a pending bit, an active bit and a programmable priority. Among the lines that are both pending and enabled it selects the most urgent one. It then tells the core whether that request may preempt the handler now running, and it supplies the request's number and its computed vector address.

Software reaches the block through a one-cycle write port. An operation code selects one of five actions: set enables, clear enables, set pendings, clear pendings, or write one line's priority. A sixth code writes the grouping value. The grouping value divides each priority into an upper preemption part and a lower subpriority part. The core answers a preemption request with an acknowledge pulse, which is handler entry. It signals the end of a handler with a return pulse, after which the running level falls back to the next active handler.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset, every enable, pending and active bit is 0, every priority is 0, the grouping value is 0, `irq_out` is 0 and `run_level` holds the idle value 2^PRIO_BITS (16 by default).
- R2: Op code 0 sets and op code 1 clears each enable bit whose `wr_mask` bit is 1. Mask bits at 0 leave their enable bits unchanged. `en_state` shows the current enable bits.
- R3: Op code 2 forces and op code 3 clears each pending bit whose `wr_mask` bit is 1. A line that is pending but not enabled never raises `irq_out`.
- R4: Op code 4 writes the 8-bit `wr_prio` to line `wr_line`. Only the upper PRIO_BITS bits (bits 7:4 by default) are kept, and the lower bits have no effect on arbitration.
- R5: Op code 5 stores the grouping value G from `wr_prio`, clamped to PRIO_BITS. The preemption level of a line is its stored priority shifted right by G. The remaining G low bits form the subpriority.
- R6: `irq_out` is 1 only when the selected request's preemption level is numerically lower than `run_level`. An equal or higher value never preempts.
- R7: The selected request is the pending and enabled line with the lowest stored priority, which orders by preemption level first and then by subpriority. On a full tie the lowest line number wins.
- R8: `irq_vector` equals VEC_BASE + 4*(16 + `irq_id`). With the default base of 0, line 2 gives 72.
- R9: When `ack` is high while `irq_out` is high, the selected line's pending bit clears, its active bit sets, and `run_level` becomes that line's preemption level. All of this is visible after the next clock edge.
- R10: A `ret` pulse clears the active bit of the most urgent active line. `run_level` then returns to the preemption level of the most urgent line still active, or to the idle value when none is active.
- R11: A request line that is high sets its pending bit on each clock edge. If the bit is cleared by acknowledge or by op code 3 while the line stays high, it sets again on the following edge. A pending bit set by a pulse on the line remains set after the line drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | N_IRQ | Level request lines |
| wr_en | input | 1 | Write strobe, one cycle |
| wr_op | input | 3 | Write operation code (0..5) |
| wr_mask | input | N_IRQ | Per-line mask for enable and pending operations |
| wr_line | input | IW | Target line for a priority write |
| wr_prio | input | 8 | Priority value or grouping value |
| ack | input | 1 | Core accepts the offered request (handler entry) |
| ret | input | 1 | Core leaves the current handler |
| irq_out | output | 1 | A request may preempt the running level |
| irq_id | output | IW | Number of the selected request |
| irq_vector | output | 32 | Vector address of the selected request |
| run_level | output | PRIO_BITS+1 | Preemption level of the running handler (idle = 2^PRIO_BITS) |
| en_state | output | N_IRQ | Enable bits |
| pend_state | output | N_IRQ | Pending bits |
| act_state | output | N_IRQ | Active bits |

## Verification
The hardest situation to reach is a two-deep nest followed by an orderly unwind. A low-urgency handler must be entered first. A more urgent line must then be forced pending and accepted on top of it. Two returns must then bring `run_level` back through the first handler's level to idle. The stimulus builds this with pending-set writes and acknowledge pulses in sequence. A table of grouping and priority pairs then drives many single-level preemption decisions. In each row, the row's grouping decides whether equal upper bits still preempt.

// File: rtl/nest_irq_pkg.sv
package nest_irq_pkg;

  typedef enum logic [2:0] {
    OP_EN_SET   = 3'd0,
    OP_EN_CLR   = 3'd1,
    OP_PEND_SET = 3'd2,
    OP_PEND_CLR = 3'd3,
    OP_PRIO     = 3'd4,
    OP_GROUP    = 3'd5
  } wr_op_e;

  // preemption part: stored priority with the subpriority bits shifted out
  function automatic logic [7:0] pre_part(input logic [7:0] prio, input logic [2:0] grp);
    return prio >> grp;
  endfunction

  // vector slot: external lines follow sixteen fixed slots of four bytes
  function automatic logic [31:0] vec_addr(input logic [31:0] base, input logic [7:0] id);
    return base + ((32'd16 + {24'd0, id}) << 2);
  endfunction

endpackage

// File: rtl/nest_irq_lines.sv
module nest_irq_lines
  import nest_irq_pkg::*;
#(
  parameter int N_IRQ     = 8,
  parameter int PRIO_BITS = 4,
  parameter int IW        = 3,
  parameter int GW        = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [N_IRQ-1:0]               irq_req,
  input  logic                           wr_en,
  input  wr_op_e                         wr_op,
  input  logic [N_IRQ-1:0]               wr_mask,
  input  logic [IW-1:0]                  wr_line,
  input  logic [7:0]                     wr_prio,
  input  logic                           take,
  input  logic [IW-1:0]                  take_id,
  input  logic                           drop,
  input  logic [IW-1:0]                  drop_id,
  output logic [N_IRQ-1:0]               en_q,
  output logic [N_IRQ-1:0]               pend_q,
  output logic [N_IRQ-1:0]               act_q,
  output logic [N_IRQ-1:0][PRIO_BITS-1:0] prio_q,
  output logic [GW-1:0]                  grp_q
);

  logic [GW-1:0] grp_d;
  assign grp_d = (wr_prio > 8'(PRIO_BITS)) ? GW'(PRIO_BITS) : GW'(wr_prio);

  always_ff @(posedge clk) begin
    if (!rst_n)
      grp_q <= '0;
    else if (wr_en && wr_op == OP_GROUP)
      grp_q <= grp_d;
  end

  for (genvar i = 0; i < N_IRQ; i++) begin : g_line
    logic en_set, en_clr, pd_set, pd_clr, act_set, act_clr, pr_wr;

    assign en_set  = wr_en && wr_op == OP_EN_SET   && wr_mask[i];
    assign en_clr  = wr_en && wr_op == OP_EN_CLR   && wr_mask[i];
    assign pd_set  = irq_req[i] || (wr_en && wr_op == OP_PEND_SET && wr_mask[i]);
    assign act_set = take && take_id == IW'(i);
    assign pd_clr  = (wr_en && wr_op == OP_PEND_CLR && wr_mask[i]) || act_set;
    assign act_clr = drop && drop_id == IW'(i);
    assign pr_wr   = wr_en && wr_op == OP_PRIO && wr_line == IW'(i);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en_q[i]   <= 1'b0;
        pend_q[i] <= 1'b0;
        act_q[i]  <= 1'b0;
        prio_q[i] <= '0;
      end else begin
        if (en_set)      en_q[i] <= 1'b1;
        else if (en_clr) en_q[i] <= 1'b0;
        if (pd_clr)      pend_q[i] <= 1'b0;
        else if (pd_set) pend_q[i] <= 1'b1;
        if (act_set)      act_q[i] <= 1'b1;
        else if (act_clr) act_q[i] <= 1'b0;
        if (pr_wr)       prio_q[i] <= wr_prio[7 -: PRIO_BITS];
      end
    end
  end

endmodule

// File: rtl/nest_irq_pick.sv
module nest_irq_pick #(
  parameter int N_IRQ     = 8,
  parameter int PRIO_BITS = 4,
  parameter int IW        = 3
) (
  input  logic [N_IRQ-1:0]                cand,
  input  logic [N_IRQ-1:0][PRIO_BITS-1:0] prio,
  output logic                            valid,
  output logic [IW-1:0]                   idx,
  output logic [PRIO_BITS-1:0]            best
);

  // strict compare keeps the lower index on a tie
  always_comb begin
    valid = 1'b0;
    idx   = '0;
    best  = '0;
    for (int i = 0; i < N_IRQ; i++) begin
      if (cand[i] && (!valid || prio[i] < best)) begin
        valid = 1'b1;
        idx   = IW'(i);
        best  = prio[i];
      end
    end
  end

endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import nest_irq_pkg::*;
#(
  parameter int          N_IRQ     = 8,
  parameter int          PRIO_BITS = 4,
  parameter logic [31:0] VEC_BASE  = 32'h0,
  localparam int         IW        = (N_IRQ > 1) ? $clog2(N_IRQ) : 1,
  localparam int         LVL_W     = PRIO_BITS + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IRQ-1:0]  irq_req,
  input  logic              wr_en,
  input  logic [2:0]        wr_op,
  input  logic [N_IRQ-1:0]  wr_mask,
  input  logic [IW-1:0]     wr_line,
  input  logic [7:0]        wr_prio,
  input  logic              ack,
  input  logic              ret,
  output logic              irq_out,
  output logic [IW-1:0]     irq_id,
  output logic [31:0]       irq_vector,
  output logic [LVL_W-1:0]  run_level,
  output logic [N_IRQ-1:0]  en_state,
  output logic [N_IRQ-1:0]  pend_state,
  output logic [N_IRQ-1:0]  act_state
);

  localparam int             GW   = $clog2(PRIO_BITS + 1);
  localparam logic [LVL_W-1:0] IDLE = LVL_W'(1 << PRIO_BITS);

  logic [N_IRQ-1:0][PRIO_BITS-1:0] prio_q;
  logic [GW-1:0]        grp_q;
  logic [N_IRQ-1:0]     pend_cand;
  logic                 best_valid, act_valid;
  logic [IW-1:0]        best_id, act_id;
  logic [PRIO_BITS-1:0] best_prio, act_prio;
  logic [LVL_W-1:0]     new_pre;
  logic                 take, drop;

  nest_irq_lines #(
    .N_IRQ(N_IRQ), .PRIO_BITS(PRIO_BITS), .IW(IW), .GW(GW)
  ) u_lines (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_req (irq_req),
    .wr_en   (wr_en),
    .wr_op   (wr_op_e'(wr_op)),
    .wr_mask (wr_mask),
    .wr_line (wr_line),
    .wr_prio (wr_prio),
    .take    (take),
    .take_id (best_id),
    .drop    (drop),
    .drop_id (act_id),
    .en_q    (en_state),
    .pend_q  (pend_state),
    .act_q   (act_state),
    .prio_q  (prio_q),
    .grp_q   (grp_q)
  );

  assign pend_cand = pend_state & en_state;

  nest_irq_pick #(.N_IRQ(N_IRQ), .PRIO_BITS(PRIO_BITS), .IW(IW)) u_pick_pend (
    .cand  (pend_cand),
    .prio  (prio_q),
    .valid (best_valid),
    .idx   (best_id),
    .best  (best_prio)
  );

  // the most urgent active line is the one running
  nest_irq_pick #(.N_IRQ(N_IRQ), .PRIO_BITS(PRIO_BITS), .IW(IW)) u_pick_act (
    .cand  (act_state),
    .prio  (prio_q),
    .valid (act_valid),
    .idx   (act_id),
    .best  (act_prio)
  );

  assign new_pre   = LVL_W'(pre_part(8'(best_prio), 3'(grp_q)));
  assign run_level = act_valid ? LVL_W'(pre_part(8'(act_prio), 3'(grp_q))) : IDLE;
  assign irq_out   = best_valid && (new_pre < run_level);
  assign irq_id    = best_id;
  assign irq_vector = vec_addr(VEC_BASE, 8'(best_id));
  assign take      = ack && irq_out;
  assign drop      = ret && act_valid;

endmodule

// File: rtl/nest_irq_chk.sv
module nest_irq_chk #(
  parameter int          N_IRQ     = 8,
  parameter int          PRIO_BITS = 4,
  parameter logic [31:0] VEC_BASE  = 32'h0,
  localparam int         IW        = (N_IRQ > 1) ? $clog2(N_IRQ) : 1,
  localparam int         LVL_W     = PRIO_BITS + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [2:0]        wr_op,
  input logic [N_IRQ-1:0]  wr_mask,
  input logic              irq_out,
  input logic [IW-1:0]     irq_id,
  input logic [31:0]       irq_vector,
  input logic [LVL_W-1:0]  run_level,
  input logic [N_IRQ-1:0]  en_state,
  input logic [N_IRQ-1:0]  pend_state,
  input logic [N_IRQ-1:0]  act_state,
  input logic              take,
  input logic              drop
);

  // R2
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_op == 3'd0) |=> ((en_state & $past(wr_mask)) == $past(wr_mask)));

  // R2
  en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_op == 3'd1) |=> ((en_state & $past(wr_mask)) == '0));

  // R3
  req_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (en_state[irq_id] && pend_state[irq_id]));

  // R6
  no_top_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (run_level != '0));

  // R8
  vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (irq_vector == VEC_BASE + 32'd64 + 32'(irq_id) * 32'd4));

  // R9
  entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> act_state[$past(irq_id)]);

  // R10
  exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !take) |=> ($countones(act_state) + 1 == $past($countones(act_state))));

endmodule

bind nest_irq_ctrl nest_irq_chk #(
  .N_IRQ(N_IRQ), .PRIO_BITS(PRIO_BITS), .VEC_BASE(VEC_BASE)
) u_chk (.*);

// File: tb/nest_irq_ctrl_bench.sv
module nest_irq_ctrl_bench;

  localparam int N  = 8;
  localparam int IW = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] irq_req = '0;
  logic         wr_en = 1'b0;
  logic [2:0]   wr_op = '0;
  logic [N-1:0] wr_mask = '0;
  logic [IW-1:0] wr_line = '0;
  logic [7:0]   wr_prio = '0;
  logic         ack = 1'b0;
  logic         ret = 1'b0;
  logic         irq_out;
  logic [IW-1:0] irq_id;
  logic [31:0]  irq_vector;
  logic [4:0]   run_level;
  logic [N-1:0] en_state, pend_state, act_state;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  nest_irq_ctrl u_nest_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .wr_en(wr_en), .wr_op(wr_op),
    .wr_mask(wr_mask), .wr_line(wr_line), .wr_prio(wr_prio), .ack(ack), .ret(ret),
    .irq_out(irq_out), .irq_id(irq_id), .irq_vector(irq_vector), .run_level(run_level),
    .en_state(en_state), .pend_state(pend_state), .act_state(act_state)
  );

  // {group[2:0], running prio[7:0], new prio[7:0], preempt}
  localparam logic [19:0] TBL [8] = '{
    {3'd0, 8'h30, 8'h10, 1'b1},
    {3'd0, 8'h30, 8'h30, 1'b0},
    {3'd0, 8'h30, 8'h40, 1'b0},
    {3'd2, 8'h30, 8'h10, 1'b0},
    {3'd2, 8'h50, 8'h30, 1'b1},
    {3'd4, 8'hF0, 8'h00, 1'b0},
    {3'd1, 8'h40, 8'h30, 1'b1},
    {3'd0, 8'h3F, 8'h30, 1'b0}
  };

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    irq_req = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] op, input logic [N-1:0] mask,
                    input logic [IW-1:0] line, input logic [7:0] prio);
    wr_en = 1'b1; wr_op = op; wr_mask = mask; wr_line = line; wr_prio = prio;
    @(negedge clk);
    wr_en = 1'b0; wr_mask = '0;
  endtask

  task automatic pulse_ack();
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic pulse_ret();
    ret = 1'b1;
    @(negedge clk);
    ret = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    check("R1 en", int'(en_state), 0);
    check("R1 pend", int'(pend_state), 0);
    check("R1 act", int'(act_state), 0);
    check("R1 irq_out", int'(irq_out), 0);
    check("R1 run_level", int'(run_level), 16);

    // R6 / R5 table of preemption decisions
    for (int k = 0; k < 8; k++) begin
      do_reset();
      wr(3'd5, '0, 0, 8'(TBL[k][19:17]));
      wr(3'd4, '0, 0, TBL[k][16:9]);
      wr(3'd4, '0, 1, TBL[k][8:1]);
      wr(3'd0, 8'h03, 0, 0);
      wr(3'd2, 8'h01, 0, 0);
      pulse_ack();
      wr(3'd2, 8'h02, 0, 0);
      check($sformatf("R6 R5 row %0d preempt", k), int'(irq_out), int'(TBL[k][0]));
      if (TBL[k][0]) check($sformatf("R6 row %0d id", k), int'(irq_id), 1);
    end

    // R2 enable write-1 semantics
    do_reset();
    wr(3'd0, 8'h05, 0, 0);
    check("R2 set", int'(en_state), 5);
    wr(3'd0, 8'h00, 0, 0);
    check("R2 zero write", int'(en_state), 5);
    wr(3'd1, 8'h01, 0, 0);
    check("R2 clear", int'(en_state), 4);

    // R3 forced pending without enable
    do_reset();
    wr(3'd2, 8'h80, 0, 0);
    check("R3 forced", int'(pend_state), 8'h80);
    check("R3 gated", int'(irq_out), 0);
    wr(3'd3, 8'h80, 0, 0);
    check("R3 clear", int'(pend_state), 0);

    // R7 R8 tie on equal priority
    do_reset();
    wr(3'd0, 8'h24, 0, 0);
    wr(3'd2, 8'h24, 0, 0);
    check("R7 tie id", int'(irq_id), 2);
    check("R8 vector", int'(irq_vector), 72);
    wr(3'd3, 8'h04, 0, 0);
    check("R8 vector id5", int'(irq_vector), 84);

    // R7 subpriority orders at equal preemption level
    do_reset();
    wr(3'd5, '0, 0, 8'd4);
    wr(3'd4, '0, 3, 8'h20);
    wr(3'd4, '0, 1, 8'h50);
    wr(3'd0, 8'h0A, 0, 0);
    wr(3'd2, 8'h0A, 0, 0);
    check("R7 sub id", int'(irq_id), 3);

    // R4 low priority bits ignored
    do_reset();
    wr(3'd4, '0, 0, 8'h3F);
    wr(3'd4, '0, 1, 8'h30);
    wr(3'd0, 8'h03, 0, 0);
    wr(3'd2, 8'h03, 0, 0);
    check("R4 low bits", int'(irq_id), 0);

    // R5 grouping clamp: 7 behaves like 4, nothing preempts level 0
    do_reset();
    wr(3'd5, '0, 0, 8'd7);
    wr(3'd4, '0, 4, 8'hF0);
    wr(3'd0, 8'h12, 0, 0);
    wr(3'd2, 8'h10, 0, 0);
    pulse_ack();
    check("R5 clamp level", int'(run_level), 0);

    // R9 R10 nesting and unwind
    do_reset();
    wr(3'd4, '0, 4, 8'h30);
    wr(3'd4, '0, 1, 8'h10);
    wr(3'd0, 8'h12, 0, 0);
    wr(3'd2, 8'h10, 0, 0);
    check("R6 idle preempt", int'(irq_out), 1);
    pulse_ack();
    check("R9 pend cleared", int'(pend_state), 0);
    check("R9 active", int'(act_state), 8'h10);
    check("R9 level", int'(run_level), 3);
    wr(3'd2, 8'h02, 0, 0);
    check("R6 nested", int'(irq_out), 1);
    pulse_ack();
    check("R9 nested act", int'(act_state), 8'h12);
    check("R9 nested level", int'(run_level), 1);
    pulse_ret();
    check("R10 act after exit", int'(act_state), 8'h10);
    check("R10 level after exit", int'(run_level), 3);
    pulse_ret();
    check("R10 idle", int'(run_level), 16);

    // R11 held line re-pends, pulsed line stays latched
    do_reset();
    wr(3'd0, 8'h40, 0, 0);
    irq_req = 8'h40;
    @(negedge clk);
    check("R11 pend", int'(pend_state), 8'h40);
    pulse_ack();
    check("R11 cleared on ack", int'(pend_state), 0);
    @(negedge clk);
    check("R11 re-pend", int'(pend_state), 8'h40);
    irq_req = 8'h20;
    @(negedge clk);
    irq_req = 8'h00;
    @(negedge clk);
    check("R11 latched", int'(pend_state & 8'h20), 8'h20);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule